// File: doc/BRIEF.md
# Floating-Point Opcode History Registers

This block keeps three small records of floating-point instruction traffic. Each record is a packed 11-bit opcode. The first record follows the instruction fetch stage. The second follows the last non-control instruction that executed. The third holds the last non-control instruction that raised an exception. Three event strobes feed it, one for prefetch, one for execution and one for exceptions. Each strobe carries the first two bytes of the instruction, and the execute and exception strobes also carry a flag that marks control instructions.

A register port reads all three records and can write only the exception record. The exception record also drives a side output into the environment-save path. A value written there through the port therefore shows up unchanged in the next saved environment image. The block never decodes instructions. It only packs bytes and filters on the control flag.

Top module: `fop_history`

## Requirements
- R1: After reset, all three records, every register-port read and `env_opcode` are zero.
- R2: A packed opcode holds the second instruction byte in bits 7:0 and the low three bits of the first byte in bits 10:8. Port address 0 reads the prefetch record, 1 the executed record and 2 the exception record. Address 3 reads zero. Read bits above bit 10 are always zero.
- R3: Every prefetch strobe loads the prefetch record on the next clock edge. When the first byte is the wait code 9Bh, the value stored is 09Bh instead of the packed form.
- R4: An execute strobe loads the executed record only when its control flag is low. When the flag is high the record keeps its value.
- R5: An exception strobe with the control flag low loads the exception record. With the flag high the record is unchanged.
- R6: A port write to address 2 stores the low 11 bits of the write data in the exception record, and `env_opcode` shows that value from the next cycle on.
- R7: Port writes to addresses 0, 1 and 3 change no record.
- R8: When a port write to address 2 and an accepted exception capture fall in the same cycle, the captured opcode is stored.
- R9: Each record changes only on its own strobe, or for the exception record on a port write. The prefetch and executed records can therefore differ.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pf_valid | input | 1 | Prefetch strobe |
| pf_byte0 | input | 8 | First byte of the prefetched instruction |
| pf_byte1 | input | 8 | Second byte of the prefetched instruction |
| ex_valid | input | 1 | Execute strobe |
| ex_byte0 | input | 8 | First byte of the executed instruction |
| ex_byte1 | input | 8 | Second byte of the executed instruction |
| ex_ctrl | input | 1 | Executed instruction is a control instruction |
| xc_valid | input | 1 | Exception strobe |
| xc_byte0 | input | 8 | First byte of the faulting instruction |
| xc_byte1 | input | 8 | Second byte of the faulting instruction |
| xc_ctrl | input | 1 | Faulting instruction is a control instruction |
| reg_addr | input | ADDR_W | Register-port address |
| reg_we | input | 1 | Register-port write enable |
| reg_wdata | input | DATA_W | Register-port write data |
| reg_rdata | output | DATA_W | Register-port read data (combinational) |
| env_opcode | output | 11 | Exception opcode for the environment-save path |

## Verification
The bench builds the block with its default parameters: a 32-bit data port, a 2-bit address and 9Bh as the wait code. With these values the zero-filled upper 21 read bits and the unmapped fourth address can both be observed. Write data with bits set above bit 10 shows that only the low 11 bits are kept. Random first bytes are pushed to 9Bh at times, so the substitute for the wait code is mixed with ordinary packing. Same-cycle port writes and exception captures come up often under random stimulus, which exercises the priority rule many times.

// File: rtl/fop_pkg.sv
package fop_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned LOW_W  = 3;
  localparam int unsigned OPC_W  = LOW_W + BYTE_W;

  typedef logic [OPC_W-1:0]  opc_t;
  typedef logic [BYTE_W-1:0] byte_t;

  // Packs the low bits of the first byte above the full second byte.
  function automatic opc_t fop_pack(input byte_t b0, input byte_t b1);
    return {b0[LOW_W-1:0], b1};
  endfunction

  // Prefetch variant: the single-byte wait instruction keeps its own byte.
  function automatic opc_t fop_pack_fetch(input byte_t b0, input byte_t b1,
                                          input byte_t wait_code);
    if (b0 == wait_code) return opc_t'(wait_code);
    return fop_pack(b0, b1);
  endfunction
endpackage

// File: rtl/fop_capture.sv
module fop_capture
  import fop_pkg::*;
#(
  parameter bit WRITABLE = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cap_en,
  input  opc_t cap_val,
  input  logic wr_en,
  input  opc_t wr_val,
  output opc_t q
);
  logic wr_go;
  assign wr_go = wr_en && WRITABLE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q <= '0;
    else if (cap_en) q <= cap_val;
    else if (wr_go)  q <= wr_val;
  end

  p_hold_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!cap_en && !wr_en) |=> $stable(q));
endmodule

// File: rtl/fop_readmux.sv
module fop_readmux
  import fop_pkg::*;
#(
  parameter int unsigned NREG   = 3,
  parameter int unsigned ADDR_W = 2,
  parameter int unsigned DATA_W = 32
) (
  input  opc_t              regs [NREG],
  input  logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] rdata
);
  localparam int unsigned PAD_W = DATA_W - OPC_W;
  logic [DATA_W-1:0] word [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_word
    assign word[g] = {{PAD_W{1'b0}}, regs[g]};
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NREG; i++) begin
      if (addr == ADDR_W'(i)) rdata = word[i];
    end
  end
endmodule

// File: rtl/fop_history.sv
module fop_history
  import fop_pkg::*;
#(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned ADDR_W    = 2,
  parameter logic [7:0]  WAIT_CODE = 8'h9B
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pf_valid,
  input  logic [7:0]        pf_byte0,
  input  logic [7:0]        pf_byte1,
  input  logic              ex_valid,
  input  logic [7:0]        ex_byte0,
  input  logic [7:0]        ex_byte1,
  input  logic              ex_ctrl,
  input  logic              xc_valid,
  input  logic [7:0]        xc_byte0,
  input  logic [7:0]        xc_byte1,
  input  logic              xc_ctrl,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic [10:0]       env_opcode
);
  localparam int unsigned NREG = 3;
  localparam logic [ADDR_W-1:0] A_PF = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_EX = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_XC = ADDR_W'(2);

  // Named internal events
  opc_t pf_pk, ex_pk, xc_pk, wr_pk;
  logic ex_fire, xc_fire, xc_wr;
  opc_t pf_q, ex_q, xc_q;
  opc_t regs [NREG];

  assign pf_pk   = fop_pack_fetch(pf_byte0, pf_byte1, WAIT_CODE);
  assign ex_pk   = fop_pack(ex_byte0, ex_byte1);
  assign xc_pk   = fop_pack(xc_byte0, xc_byte1);
  assign wr_pk   = reg_wdata[OPC_W-1:0];
  assign ex_fire = ex_valid && !ex_ctrl;
  assign xc_fire = xc_valid && !xc_ctrl;
  assign xc_wr   = reg_we && (reg_addr == A_XC);

  fop_capture #(.WRITABLE(1'b0)) u_pf (
    .clk(clk), .rst_n(rst_n), .cap_en(pf_valid), .cap_val(pf_pk),
    .wr_en(1'b0), .wr_val('0), .q(pf_q));

  fop_capture #(.WRITABLE(1'b0)) u_ex (
    .clk(clk), .rst_n(rst_n), .cap_en(ex_fire), .cap_val(ex_pk),
    .wr_en(1'b0), .wr_val('0), .q(ex_q));

  fop_capture #(.WRITABLE(1'b1)) u_xc (
    .clk(clk), .rst_n(rst_n), .cap_en(xc_fire), .cap_val(xc_pk),
    .wr_en(xc_wr), .wr_val(wr_pk), .q(xc_q));

  assign regs[0] = pf_q;
  assign regs[1] = ex_q;
  assign regs[2] = xc_q;

  fop_readmux #(.NREG(NREG), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd (
    .regs(regs), .addr(reg_addr), .rdata(reg_rdata));

  assign env_opcode = xc_q;

  p_hi_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[DATA_W-1:OPC_W] == '0);
  p_pf_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pf_valid |=> pf_q == $past(pf_pk));
  p_ex_filter_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_valid && ex_ctrl) |=> $stable(ex_q));
  p_xc_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
    xc_fire |=> xc_q == $past(xc_pk));
  p_env_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (xc_wr && !xc_fire) |=> env_opcode == $past(wr_pk));
  p_ro_pf_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == A_PF && !pf_valid) |=> $stable(pf_q));
  p_ro_ex_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == A_EX && !ex_fire) |=> $stable(ex_q));
  p_capture_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (xc_fire && xc_wr) |=> env_opcode == $past(xc_pk));
endmodule

// File: tb/fop_history_tb_top.sv
module fop_history_tb_top;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pf_valid = 0, ex_valid = 0, ex_ctrl = 0, xc_valid = 0, xc_ctrl = 0;
  logic [7:0] pf_byte0 = 0, pf_byte1 = 0, ex_byte0 = 0, ex_byte1 = 0;
  logic [7:0] xc_byte0 = 0, xc_byte1 = 0;
  logic [ADDR_W-1:0] reg_addr = 0;
  logic reg_we = 0;
  logic [DATA_W-1:0] reg_wdata = 0;
  logic [DATA_W-1:0] reg_rdata;
  logic [10:0] env_opcode;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int m_pf = 0, m_ex = 0, m_xc = 0;

  always #10 clk = ~clk;

  fop_history dut_i (
    .clk(clk), .rst_n(rst_n),
    .pf_valid(pf_valid), .pf_byte0(pf_byte0), .pf_byte1(pf_byte1),
    .ex_valid(ex_valid), .ex_byte0(ex_byte0), .ex_byte1(ex_byte1), .ex_ctrl(ex_ctrl),
    .xc_valid(xc_valid), .xc_byte0(xc_byte0), .xc_byte1(xc_byte1), .xc_ctrl(xc_ctrl),
    .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .env_opcode(env_opcode));

  function automatic int enc(input int b0, input int b1, input bit fetch);
    if (fetch && b0 == 'h9B) return 'h9B;
    return ((b0 % 8) * 256) + b1;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic rd(input int a, output int v);
    reg_addr = ADDR_W'(a);
    #1;
    v = int'(reg_rdata);
  endtask

  task automatic verify(input string req);
    int v;
    rd(0, v); chk({req, " pf"}, v, m_pf);
    rd(1, v); chk({req, " ex"}, v, m_ex);
    rd(2, v); chk({req, " xc"}, v, m_xc);
    rd(3, v); chk({req, " addr3"}, v, 0);
    chk({req, " env"}, int'(env_opcode), m_xc);
  endtask

  task automatic clear_in();
    pf_valid = 0; ex_valid = 0; xc_valid = 0; ex_ctrl = 0; xc_ctrl = 0;
    reg_we = 0; reg_wdata = '0;
  endtask

  // Model update from the inputs seen at the clock edge, then check.
  task automatic tick(input string req);
    @(posedge clk);
    if (pf_valid) m_pf = enc(pf_byte0, pf_byte1, 1);
    if (ex_valid && !ex_ctrl) m_ex = enc(ex_byte0, ex_byte1, 0);
    if (xc_valid && !xc_ctrl) m_xc = enc(xc_byte0, xc_byte1, 0);
    else if (reg_we && reg_addr == 2) m_xc = int'(reg_wdata & 32'h7FF);
    @(negedge clk);
    clear_in();
    verify(req);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int v;
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    verify("R1");
    rst_n = 1'b1;
    @(negedge clk);
    verify("R1");

    // R2 R3: packing and the wait substitute
    pf_valid = 1; pf_byte0 = 8'hD9; pf_byte1 = 8'hC0; tick("R2");
    chk("R2 packed", m_pf, 'h1C0);
    pf_valid = 1; pf_byte0 = 8'h9B; pf_byte1 = 8'h55; tick("R3");
    chk("R3 wait", m_pf, 'h09B);
    // R4: control filtered, then accepted
    ex_valid = 1; ex_ctrl = 1; ex_byte0 = 8'hD9; ex_byte1 = 8'h30; tick("R4");
    chk("R4 ctrl kept", m_ex, 0);
    ex_valid = 1; ex_ctrl = 0; ex_byte0 = 8'hDE; ex_byte1 = 8'hC9; tick("R4");
    chk("R4 load", m_ex, 'h6C9);
    // R9: prefetch only, executed stays
    pf_valid = 1; pf_byte0 = 8'hDD; pf_byte1 = 8'hD8; tick("R9");
    rd(1, v); chk("R9 ex untouched", v, 'h6C9);
    // R5
    xc_valid = 1; xc_ctrl = 1; xc_byte0 = 8'hD8; xc_byte1 = 8'h11; tick("R5");
    xc_valid = 1; xc_ctrl = 0; xc_byte0 = 8'hDC; xc_byte1 = 8'hF1; tick("R5");
    chk("R5 load", m_xc, 'h4F1);
    // R6: write with bits above 10
    reg_we = 1; reg_addr = 2; reg_wdata = 32'hFFFF_F5A5; tick("R6");
    chk("R6 env", int'(env_opcode), 'h5A5);
    // R7: writes elsewhere ignored
    for (int a = 0; a < 4; a++) begin
      if (a == 2) continue;
      reg_we = 1; reg_addr = ADDR_W'(a); reg_wdata = 32'h0000_07FF; tick("R7");
    end
    // R8: capture beats write
    reg_we = 1; reg_addr = 2; reg_wdata = 32'h123;
    xc_valid = 1; xc_ctrl = 0; xc_byte0 = 8'hDB; xc_byte1 = 8'hE2; tick("R8");
    chk("R8 capture wins", int'(env_opcode), 'h3E2);
    // R6 counterpart: control exception does not block a write
    reg_we = 1; reg_addr = 2; reg_wdata = 32'h2AA;
    xc_valid = 1; xc_ctrl = 1; tick("R6");

    for (int i = 0; i < 600; i++) begin
      pf_valid = 1'($urandom % 2);
      pf_byte0 = ($urandom % 4 == 0) ? 8'h9B : 8'($urandom);
      pf_byte1 = 8'($urandom);
      ex_valid = 1'($urandom % 2); ex_ctrl = 1'($urandom % 2);
      ex_byte0 = 8'($urandom); ex_byte1 = 8'($urandom);
      xc_valid = 1'($urandom % 3 == 0); xc_ctrl = 1'($urandom % 2);
      xc_byte0 = 8'($urandom); xc_byte1 = 8'($urandom);
      reg_we = 1'($urandom % 2); reg_addr = ADDR_W'($urandom);
      reg_wdata = $urandom;
      tick("R9 random");
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule